// File: doc/BRIEF.md
# Data-Port Bus Master with Arbitration and Wait States

This block sits between a processor core and a shared data-memory bus that several masters may own in turn. The core presents one word-sized read or write at a time on a valid/ready interface, together with a flag that selects memory space or I/O space. The block then requests the bus, waits until the external arbiter grants it and the previous owner has let go, and announces ownership on its own acknowledge line.

While it owns the bus, the block drives a 16-bit word address, the space and direction qualifiers, a data strobe and, for memory space only, an output-enable or write-enable strobe. For writes it also drives the data. The slave sets the cycle length: the block holds every driven line until the slave raises its transfer acknowledge. On the clock edge where that acknowledge is seen, the block captures read data, returns a one-clock ready pulse to the core and releases every bus line. The block never keeps the bus from one transfer to the next. A core that has a further request waiting makes the block pass through idle and arbitrate again.

Top module: `dport_master`

## Requirements
- R1: A synchronous reset, applied in any state, leaves `bus_req`, `bus_own`, `core_ready`, `addr_oe`, `data_oe`, `bus_dstrobe`, `mem_oe` and `mem_we` all low after the next rising edge.
- R2: While idle with no core request, `bus_req` stays low, whatever the grant and busy inputs do.
- R3: One rising edge after an idle block sees `core_valid`, it raises `bus_req`. The request stays high with `bus_own` low until ownership is taken.
- R4: `bus_grant` and `bus_busy` are sampled on the falling clock edge. `bus_own` rises only at a rising edge whose preceding falling edge saw grant high and busy low. `bus_req` falls on that same edge, and the two are never high together.
- R5: While `bus_own` is high, `addr_oe` is high and `bus_addr` carries the request address. `bus_mem` is 1 for memory space and 0 for I/O space. `bus_rd` is 1 for a read and 0 for a write. `bus_dstrobe` is 1. `data_oe` is 1 only for writes, with `bus_wdata` carrying the write data.
- R6: Ownership and every driven line hold, unchanged, for as many clocks as `xfer_ack` stays low.
- R7: On the rising edge where `xfer_ack` is first sampled high, `core_rdata` takes `bus_rdata` for reads. After that edge, `core_ready` is high for exactly one clock, and `bus_own`, `addr_oe` and `data_oe` are low.
- R8: A core request that is still pending at the end of a cycle does not keep the bus. `bus_req` and `bus_own` both stay low for one clock, and `bus_req` rises again on the edge after that.
- R9: `mem_oe` is high only for memory-space reads and `mem_we` only for memory-space writes. Both stay low for I/O space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge sequences, falling edge samples arbitration |
| rst | input | 1 | Synchronous reset, active high |
| core_valid | input | 1 | Core request pending, held until `core_ready` |
| core_write | input | 1 | 1 = write, 0 = read |
| core_io | input | 1 | 1 = I/O space, 0 = memory space |
| core_addr | input | 16 | Word address |
| core_wdata | input | 16 | Write data |
| core_ready | output | 1 | One-clock completion pulse |
| core_rdata | output | 16 | Read data captured from the bus |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bus_busy | input | 1 | Previous master still holds the bus |
| bus_own | output | 1 | Grant acknowledge: block owns the bus |
| bus_addr | output | 16 | Address bus value |
| addr_oe | output | 1 | Drive enable for address and qualifiers |
| bus_wdata | output | 16 | Data bus value for writes |
| data_oe | output | 1 | Drive enable for the data bus |
| bus_rdata | input | 16 | Data bus value returned by the slave |
| bus_mem | output | 1 | 1 = memory space, 0 = I/O space |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_dstrobe | output | 1 | Data strobe |
| mem_oe | output | 1 | Memory output enable |
| mem_we | output | 1 | Memory write enable |
| xfer_ack | input | 1 | Slave transfer acknowledge |

## Verification
Two events can fall in the same cycle: the slave acknowledge that ends a transfer, and a core request that is already waiting for the next one. The bench provokes this by keeping `core_valid` high through the ready pulse. It then checks that ready pulses only once and that the bus goes fully idle for one clock before `bus_req` rises again. A second collision arises when grant arrives while the previous master still shows busy. Here the bench checks that ownership waits until busy clears at a falling edge.

// File: rtl/dport_pkg.sv
package dport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_OWN  = 2'd2,
        ST_DONE = 2'd3
    } dport_state_e;

endpackage

// File: rtl/dport_negsample.sv
module dport_negsample #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] sig_q
);
    logic [W-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = rst ? '0 : sig_in;
    end

    always_ff @(negedge clk) begin
        smp_q <= smp_d;
    end

    assign sig_q = smp_q;
endmodule

// File: rtl/dport_ctrl.sv
module dport_ctrl
    import dport_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_valid,
    input  logic          core_write,
    input  logic          core_io,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_ready,
    output logic [DW-1:0] core_rdata,
    input  logic          grant_s,
    input  logic          busy_s,
    input  logic          xfer_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_own,
    output logic [AW-1:0] bus_addr,
    output logic          addr_oe,
    output logic [DW-1:0] bus_wdata,
    output logic          data_oe,
    output logic          bus_mem,
    output logic          bus_rd,
    output logic          bus_dstrobe,
    output logic          mem_oe,
    output logic          mem_we
);
    typedef struct packed {
        dport_state_e  state;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          write;
        logic          io;
        logic          req;
        logic          own;
        logic          ready;
        logic          adrv;
        logic          ddrv;
        logic          strb;
        logic          oe;
        logic          we;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       won;

    assign won = grant_s & ~busy_s;

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (core_valid) begin
                    r_d.state = ST_ARB;
                    r_d.addr  = core_addr;
                    r_d.wdata = core_wdata;
                    r_d.write = core_write;
                    r_d.io    = core_io;
                    r_d.req   = 1'b1;
                end
            end
            ST_ARB: begin
                if (won) begin
                    r_d.state = ST_OWN;
                    r_d.req   = 1'b0;
                    r_d.own   = 1'b1;
                    r_d.adrv  = 1'b1;
                    r_d.ddrv  = r_q.write;
                    r_d.strb  = 1'b1;
                    r_d.oe    = ~r_q.io & ~r_q.write;
                    r_d.we    = ~r_q.io & r_q.write;
                end
            end
            ST_OWN: begin
                if (xfer_ack) begin
                    r_d.state = ST_DONE;
                    if (!r_q.write) r_d.rdata = bus_rdata;
                    r_d.own   = 1'b0;
                    r_d.adrv  = 1'b0;
                    r_d.ddrv  = 1'b0;
                    r_d.strb  = 1'b0;
                    r_d.oe    = 1'b0;
                    r_d.we    = 1'b0;
                    r_d.ready = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (rst) begin
            r_d       = r_q;
            r_d.state = ST_IDLE;
            r_d.req   = 1'b0;
            r_d.own   = 1'b0;
            r_d.ready = 1'b0;
            r_d.adrv  = 1'b0;
            r_d.ddrv  = 1'b0;
            r_d.strb  = 1'b0;
            r_d.oe    = 1'b0;
            r_d.we    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign core_ready  = r_q.ready;
    assign core_rdata  = r_q.rdata;
    assign bus_req     = r_q.req;
    assign bus_own     = r_q.own;
    assign bus_addr    = r_q.addr;
    assign addr_oe     = r_q.adrv;
    assign bus_wdata   = r_q.wdata;
    assign data_oe     = r_q.ddrv;
    assign bus_mem     = ~r_q.io;
    assign bus_rd      = ~r_q.write;
    assign bus_dstrobe = r_q.strb;
    assign mem_oe      = r_q.oe;
    assign mem_we      = r_q.we;

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_IDLE && !core_valid) |=> !bus_req);

    assert_req_own_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_own));

    assert_own_needs_win_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_own) |-> $past(grant_s && !busy_s));

    assert_drive_only_owned_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_oe || data_oe || bus_dstrobe) |-> bus_own);

    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_own && !xfer_ack) |=> (bus_own && $stable(bus_addr) && $stable(data_oe)));

    assert_release_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_own && xfer_ack) |=> (!bus_own && !addr_oe && !data_oe && core_ready));

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (rst)
        core_ready |=> !core_ready);

    assert_no_hold_after_R8: assert property (@(posedge clk) disable iff (rst)
        core_ready |-> (!bus_req && !bus_own));

    assert_io_no_mem_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_own && !bus_mem) |-> (!mem_oe && !mem_we));
endmodule

// File: rtl/dport_master.sv
module dport_master #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_valid,
    input  logic          core_write,
    input  logic          core_io,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_ready,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          bus_busy,
    output logic          bus_own,
    output logic [AW-1:0] bus_addr,
    output logic          addr_oe,
    output logic [DW-1:0] bus_wdata,
    output logic          data_oe,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_mem,
    output logic          bus_rd,
    output logic          bus_dstrobe,
    output logic          mem_oe,
    output logic          mem_we,
    input  logic          xfer_ack
);
    localparam int ARB_W = 2;

    logic [ARB_W-1:0] arb_q;

    dport_negsample #(.W(ARB_W)) u_smp (
        .clk    (clk),
        .rst    (rst),
        .sig_in ({bus_grant, bus_busy}),
        .sig_q  (arb_q)
    );

    dport_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .core_valid  (core_valid),
        .core_write  (core_write),
        .core_io     (core_io),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_ready  (core_ready),
        .core_rdata  (core_rdata),
        .grant_s     (arb_q[1]),
        .busy_s      (arb_q[0]),
        .xfer_ack    (xfer_ack),
        .bus_rdata   (bus_rdata),
        .bus_req     (bus_req),
        .bus_own     (bus_own),
        .bus_addr    (bus_addr),
        .addr_oe     (addr_oe),
        .bus_wdata   (bus_wdata),
        .data_oe     (data_oe),
        .bus_mem     (bus_mem),
        .bus_rd      (bus_rd),
        .bus_dstrobe (bus_dstrobe),
        .mem_oe      (mem_oe),
        .mem_we      (mem_we)
    );
endmodule

// File: tb/tb_dport_master.sv
module tb_dport_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_valid = 1'b0, core_write = 1'b0, core_io = 1'b0;
    logic [15:0] core_addr = '0, core_wdata = '0, bus_rdata = '0;
    logic        bus_grant = 1'b0, bus_busy = 1'b0, xfer_ack = 1'b0;
    logic        core_ready, bus_req, bus_own, addr_oe, data_oe;
    logic        bus_mem, bus_rd, bus_dstrobe, mem_oe, mem_we;
    logic [15:0] core_rdata, bus_addr, bus_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dport_master dut (
        .clk(clk), .rst(rst), .core_valid(core_valid), .core_write(core_write),
        .core_io(core_io), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ready(core_ready), .core_rdata(core_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_busy(bus_busy), .bus_own(bus_own),
        .bus_addr(bus_addr), .addr_oe(addr_oe), .bus_wdata(bus_wdata),
        .data_oe(data_oe), .bus_rdata(bus_rdata), .bus_mem(bus_mem),
        .bus_rd(bus_rd), .bus_dstrobe(bus_dstrobe), .mem_oe(mem_oe),
        .mem_we(mem_we), .xfer_ack(xfer_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_released(input string tag);
        chk({tag, " bus_req"}, 32'(bus_req), 0);
        chk({tag, " bus_own"}, 32'(bus_own), 0);
        chk({tag, " addr_oe"}, 32'(addr_oe), 0);
        chk({tag, " data_oe"}, 32'(data_oe), 0);
        chk({tag, " strobes"}, {29'd0, bus_dstrobe, mem_oe, mem_we}, 0);
    endtask

    // full transfer; ends one clock after the ready pulse (block idle)
    task automatic run_xfer(input logic wr, input logic io, input logic [15:0] a,
                            input logic [15:0] wd, input int gwait, input int bwait,
                            input int ws, input logic [15:0] rd, input bit keep);
        core_valid = 1'b1; core_write = wr; core_io = io;
        core_addr = a; core_wdata = wd;
        bus_grant = 1'b0; bus_busy = 1'b0;
        step();
        chk("R3 req raised", 32'(bus_req), 1);
        chk("R3 not owned yet", 32'(bus_own), 0);
        for (int i = 0; i < gwait; i++) begin
            step();
            chk("R3 req held no grant", 32'(bus_req), 1);
            chk("R4 no own without grant", 32'(bus_own), 0);
        end
        bus_grant = 1'b1; bus_busy = 1'b1;
        for (int i = 0; i < bwait; i++) begin
            step();
            chk("R4 no own while busy", 32'(bus_own), 0);
            chk("R5 no drive unowned", 32'(addr_oe), 0);
        end
        bus_busy = 1'b0;
        step();
        chk("R4 own taken", 32'(bus_own), 1);
        chk("R4 req dropped", 32'(bus_req), 0);
        for (int i = 0; i <= ws; i++) begin
            chk("R5 addr_oe", 32'(addr_oe), 1);
            chk("R5 addr", 32'(bus_addr), 32'(a));
            chk("R5 space", 32'(bus_mem), 32'(!io));
            chk("R5 direction", 32'(bus_rd), 32'(!wr));
            chk("R5 dstrobe", 32'(bus_dstrobe), 1);
            chk("R5 data_oe", 32'(data_oe), 32'(wr));
            if (wr) chk("R5 wdata", 32'(bus_wdata), 32'(wd));
            chk("R9 mem_oe", 32'(mem_oe), 32'(!io && !wr));
            chk("R9 mem_we", 32'(mem_we), 32'(!io && wr));
            chk("R6 ready low while waiting", 32'(core_ready), 0);
            if (i < ws) begin
                step();
                chk("R6 own held in wait", 32'(bus_own), 1);
            end
        end
        bus_grant = 1'b0;
        xfer_ack = 1'b1; bus_rdata = rd;
        step();
        xfer_ack = 1'b0; bus_rdata = 16'hDEAD;
        chk("R7 ready pulse", 32'(core_ready), 1);
        chk_released("R7 released");
        if (!wr) chk("R7 rdata", 32'(core_rdata), 32'(rd));
        if (!keep) core_valid = 1'b0;
        step();
        chk("R7 ready one clock", 32'(core_ready), 0);
        chk_released("R8 idle gap");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk_released("R1 reset");
        chk("R1 ready", 32'(core_ready), 0);
        rst = 1'b0;
    endtask

    task automatic t_idle_quiet();
        bus_grant = 1'b1; bus_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R2 idle no req", 32'(bus_req), 0);
            chk("R2 idle no own", 32'(bus_own), 0);
        end
        bus_busy = 1'b1;
        step();
        chk("R2 idle no req busy", 32'(bus_req), 0);
        bus_grant = 1'b0; bus_busy = 1'b0;
    endtask

    task automatic t_mem_read();
        run_xfer(1'b0, 1'b0, 16'h1234, 16'h0, 2, 0, 3, 16'hA5C3, 1'b0);
    endtask

    task automatic t_mem_write();
        run_xfer(1'b1, 1'b0, 16'hFFFF, 16'h5A0F, 0, 2, 0, 16'h0, 1'b0);
    endtask

    task automatic t_io_access();
        run_xfer(1'b0, 1'b1, 16'h0040, 16'h0, 1, 1, 1, 16'h7E81, 1'b0);
        run_xfer(1'b1, 1'b1, 16'h0000, 16'h9999, 0, 0, 2, 16'h0, 1'b0);
    endtask

    task automatic t_back_to_back();
        run_xfer(1'b0, 1'b0, 16'h0100, 16'h0, 0, 0, 0, 16'h1111, 1'b1);
        core_addr = 16'h0102; core_write = 1'b1; core_wdata = 16'h2222;
        step();
        chk("R8 re-arbitrate", 32'(bus_req), 1);
        chk("R8 not owned", 32'(bus_own), 0);
        bus_grant = 1'b1;
        step();
        chk("R8 second own", 32'(bus_own), 1);
        chk("R8 second addr", 32'(bus_addr), 32'h0102);
        chk("R8 second data_oe", 32'(data_oe), 1);
        bus_grant = 1'b0; xfer_ack = 1'b1;
        step();
        xfer_ack = 1'b0; core_valid = 1'b0;
        chk("R8 second ready", 32'(core_ready), 1);
        step();
        chk_released("R8 done");
    endtask

    task automatic t_reset_mid();
        core_valid = 1'b1; core_write = 1'b1; core_io = 1'b0;
        core_addr = 16'h0BAD; core_wdata = 16'h0F0F;
        step();
        bus_grant = 1'b1;
        step();
        chk("R1 pre-reset own", 32'(bus_own), 1);
        rst = 1'b1; core_valid = 1'b0; bus_grant = 1'b0;
        step();
        chk_released("R1 mid reset");
        chk("R1 mid ready", 32'(core_ready), 0);
        rst = 1'b0;
        step();
        chk_released("R1 after reset");
    endtask

    initial begin
        t_reset();
        t_idle_quiet();
        t_mem_read();
        t_mem_write();
        t_io_access();
        t_back_to_back();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule